// File: doc/BRIEF.md
# Start-Up Sequencer with Option Load

This block brings a small 4-bit microcontroller core out of reset in a fixed order. While the active-low reset pin is low, everything it drives is cleared and the core stays stopped. Once the pin goes high, the release passes through a two-flop synchroniser. The block then counts out an oscillator settling interval. After that it opens a load window of fixed length, measured in oscillator clocks. In that window it reads the non-volatile option area through a synchronous read port and copies each word into an option register. When the window closes, it tells the core to load its program counter with zero, and on the next cycle it lets the core run.

The option words are read at consecutive addresses starting from zero, one per clock, at the start of the window. The rest of the window is idle time that keeps the total length fixed. A low level on the reset pin clears the synchroniser at once, whatever the sequence is doing, so the whole sequence starts again from the beginning.

Top module: `rso_seq_top`

## Requirements
- R1: While `rst_n_pin` is low, `pc_load`, `core_run`, `seq_done` and `opt_rd` are 0 and every option register reads 0. A falling edge on the pin forces this state at once, without waiting for a clock edge.
- R2: The pin's release is synchronised by two flops. The sequencer leaves its held state on the third rising clock edge after release.
- R3: After leaving the held state, the block waits exactly `STAB_CYCLES` clocks (default 16384) with `opt_rd` low. The first option read is therefore issued on edge `STAB_CYCLES+3` counted from release.
- R4: The load window lasts exactly `LOAD_CYCLES` clocks (default 512, about 128 µs at 4 MHz). `pc_load` is high after edge `STAB_CYCLES+LOAD_CYCLES+3`.
- R5: In the window, `opt_rd` is high for exactly `NUM_WORDS` consecutive cycles, with `opt_addr` going 0, 1, 2, ... one step per cycle. It is low for the rest of the window.
- R6: The option port returns data on the edge after a read. Word k lands in `opt_regs[k*DATA_W +: DATA_W]` on the second edge after its address was issued, and is still at its reset value one edge earlier.
- R7: `pc_load` (the command to load the program counter with 0000h) is high for exactly one cycle.
- R8: `core_run` rises in the cycle after `pc_load` and stays high until reset.
- R9: `seq_done` is a single-cycle pulse in the same cycle as `pc_load`.
- R10: After the window, changes on `opt_rdata` do not alter the option registers.
- R11: A reset pulse in the middle of the load window clears the option registers at once. After release, the full sequence runs again with the timing of R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n_pin | input | 1 | Active-low reset pin, asynchronous |
| opt_rd | output | 1 | Read strobe to the option area |
| opt_addr | output | ADDR_W | Option word address |
| opt_rdata | input | DATA_W | Option data, valid the cycle after a read |
| opt_regs | output | NUM_WORDS*DATA_W | Captured option registers, word k in bits k*DATA_W upward |
| pc_load | output | 1 | Load program counter with zero |
| core_run | output | 1 | Core execution enable |
| seq_done | output | 1 | One-cycle pulse at release |

## Verification
The bench sweeps several option patterns through a reduced configuration and also runs the full default sequence once. It measures the exact edge of the first read and of the program-counter load, so a design that counts one cycle too few or too many in either phase, or that adds a synchroniser stage, shifts these edges and is reported. It checks the edge on which word 0 is captured, which catches a capture one cycle early (before the memory responds) or one cycle late. A reset is pulled in the middle of the window and again while running; a design that waits for a clock edge, or keeps the words it has already loaded, fails there. Changing memory data after release would expose option registers that keep capturing.

// File: rtl/rso_pkg.sv
package rso_pkg;

  typedef enum logic [2:0] {
    PH_HOLD,
    PH_STAB,
    PH_LOAD,
    PH_PCLD,
    PH_RUN
  } phase_e;

  // number of flops between pin release and the first sequencer transition
  localparam int unsigned SYNC_LAT = 3;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned first_read_edge(input int unsigned stab);
    return stab + SYNC_LAT;
  endfunction

  function automatic int unsigned release_edge(input int unsigned stab, input int unsigned load);
    return stab + load + SYNC_LAT;
  endfunction

endpackage

// File: rtl/rso_rst_sync.sv
module rso_rst_sync (
  input  logic clk,
  input  logic rst_n_pin,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_pin) begin
    if (!rst_n_pin) sync_q <= 2'b00;
    else            sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/rso_phase_ctrl.sv
module rso_phase_ctrl
  import rso_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 16384,
  parameter int unsigned LOAD_CYCLES = 512,
  parameter int unsigned NUM_WORDS   = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned CNT_W       = 15
) (
  input  logic              clk,
  input  logic              rst_s,
  output phase_e            phase,
  output logic              opt_rd,
  output logic [ADDR_W-1:0] opt_addr,
  output logic              stab_end,
  output logic              load_end
);
  logic [CNT_W-1:0] cnt_q;

  assign stab_end = (phase == PH_STAB) && (cnt_q == CNT_W'(STAB_CYCLES - 1));
  assign load_end = (phase == PH_LOAD) && (cnt_q == CNT_W'(LOAD_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      phase <= PH_HOLD;
      cnt_q <= '0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          phase <= PH_STAB;
          cnt_q <= '0;
        end
        PH_STAB: begin
          if (stab_end) begin
            phase <= PH_LOAD;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_LOAD: begin
          if (load_end) begin
            phase <= PH_PCLD;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PCLD: phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign opt_rd   = (phase == PH_LOAD) && (cnt_q < CNT_W'(NUM_WORDS));
  assign opt_addr = cnt_q[ADDR_W-1:0];
endmodule

// File: rtl/rso_opt_capture.sv
module rso_opt_capture #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_s,
  input  logic                        opt_rd,
  input  logic [ADDR_W-1:0]           opt_addr,
  input  logic [DATA_W-1:0]           opt_rdata,
  output logic                        cap_en,
  output logic [NUM_WORDS*DATA_W-1:0] opt_regs
);
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= opt_rd;
      addr_q <= opt_addr;
    end
  end

  assign cap_en = rd_q;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s)                              word_q <= '0;
      else if (rd_q && addr_q == ADDR_W'(k))   word_q <= opt_rdata;
    end
    assign opt_regs[k*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/rso_seq_top.sv
module rso_seq_top
  import rso_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 16384,
  parameter int unsigned LOAD_CYCLES = 512,
  parameter int unsigned NUM_WORDS   = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n_pin,
  output logic                        opt_rd,
  output logic [ADDR_W-1:0]           opt_addr,
  input  logic [DATA_W-1:0]           opt_rdata,
  output logic [NUM_WORDS*DATA_W-1:0] opt_regs,
  output logic                        pc_load,
  output logic                        core_run,
  output logic                        seq_done
);
  localparam int unsigned CNT_W = $clog2(max2(STAB_CYCLES, LOAD_CYCLES) + 1);

  logic   rst_s;
  phase_e phase;
  logic   stab_end;
  logic   load_end;
  logic   cap_en;
  logic   done_q;

  rso_rst_sync u_sync (
    .clk       (clk),
    .rst_n_pin (rst_n_pin),
    .rst_s     (rst_s)
  );

  rso_phase_ctrl #(
    .STAB_CYCLES (STAB_CYCLES),
    .LOAD_CYCLES (LOAD_CYCLES),
    .NUM_WORDS   (NUM_WORDS),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_s    (rst_s),
    .phase    (phase),
    .opt_rd   (opt_rd),
    .opt_addr (opt_addr),
    .stab_end (stab_end),
    .load_end (load_end)
  );

  rso_opt_capture #(
    .NUM_WORDS (NUM_WORDS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_cap (
    .clk       (clk),
    .rst_s     (rst_s),
    .opt_rd    (opt_rd),
    .opt_addr  (opt_addr),
    .opt_rdata (opt_rdata),
    .cap_en    (cap_en),
    .opt_regs  (opt_regs)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) done_q <= 1'b0;
    else        done_q <= load_end;
  end

  assign pc_load  = (phase == PH_PCLD);
  assign core_run = (phase == PH_RUN);
  assign seq_done = done_q;
endmodule

// File: rtl/rso_seq_chk.sv
module rso_seq_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_s,
  input logic              opt_rd,
  input logic [ADDR_W-1:0] opt_addr,
  input logic              stab_end,
  input logic              pc_load,
  input logic              core_run,
  input logic              seq_done
);
  assert_held_in_reset_R1: assert property (@(posedge clk)
    !rst_s |-> (!core_run && !opt_rd && !pc_load && !seq_done));

  assert_first_read_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_s)
    stab_end |=> (opt_rd && opt_addr == '0));

  assert_addr_steps_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (opt_rd && $past(opt_rd)) |-> (opt_addr == $past(opt_addr) + 1'b1));

  assert_pc_load_single_R7: assert property (@(posedge clk) disable iff (!rst_s)
    pc_load |=> !pc_load);

  assert_run_follows_load_R8: assert property (@(posedge clk) disable iff (!rst_s)
    pc_load |=> core_run);

  assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_s)
    core_run |=> core_run);

  assert_done_with_load_R9: assert property (@(posedge clk) disable iff (!rst_s)
    seq_done |-> (pc_load && !core_run));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_s)
    seq_done |=> !seq_done);
endmodule

bind rso_seq_top rso_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .opt_rd   (opt_rd),
  .opt_addr (opt_addr),
  .stab_end (stab_end),
  .pc_load  (pc_load),
  .core_run (core_run),
  .seq_done (seq_done)
);

// File: tb/rso_seq_top_tb.sv
module rso_seq_top_tb;
  localparam int CLK_P = 10;
  localparam int STAB  = 20;
  localparam int LOAD  = 16;
  localparam int NW    = 4;
  localparam int DW    = 8;
  localparam int AW    = 2;
  localparam int F_STAB = 16384;
  localparam int F_LOAD = 512;
  localparam int F_NW   = 8;
  localparam int F_AW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] seed = 8'h00;

  logic          opt_rd, pc_load, core_run, seq_done;
  logic [AW-1:0] opt_addr;
  logic [DW-1:0] opt_rdata = '0;
  logic [NW*DW-1:0] opt_regs;

  logic            f_rd, f_pc, f_run, f_done;
  logic [F_AW-1:0] f_addr;
  logic [DW-1:0]   f_rdata = '0;
  logic [F_NW*DW-1:0] f_regs;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pat(input int a, input logic [7:0] s);
    return 8'((a * 37 + 5) & 8'hff) ^ s;
  endfunction

  always @(posedge clk) begin
    if (opt_rd) opt_rdata <= pat(int'(opt_addr), seed);
    if (f_rd)   f_rdata   <= pat(int'(f_addr), seed);
  end

  rso_seq_top #(.STAB_CYCLES(STAB), .LOAD_CYCLES(LOAD), .NUM_WORDS(NW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n_pin(rst_n), .opt_rd(opt_rd), .opt_addr(opt_addr),
    .opt_rdata(opt_rdata), .opt_regs(opt_regs), .pc_load(pc_load),
    .core_run(core_run), .seq_done(seq_done)
  );

  rso_seq_top u_dut_full (
    .clk(clk), .rst_n_pin(rst_n), .opt_rd(f_rd), .opt_addr(f_addr),
    .opt_rdata(f_rdata), .opt_regs(f_regs), .pc_load(f_pc),
    .core_run(f_run), .seq_done(f_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_cleared(input string tag);
    chk(tag, {60'd0, pc_load, core_run, seq_done, opt_rd}, 64'd0);
    chk(tag, 64'(opt_regs), 64'd0);
  endtask

  task automatic run_seq(input logic [7:0] s);
    int n = 0, first_rd = 0, pc_n = 0, run_n = 0, dones = 0, rds = 0, addr_bad = 0, exp_addr = 0;
    logic [NW*DW-1:0] snap;
    seed = s;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_cleared("R1 held");
    rst_n = 1'b1;
    while (run_n == 0 && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (opt_rd) begin
        if (first_rd == 0) first_rd = n;
        if (int'(opt_addr) != exp_addr) addr_bad++;
        exp_addr++; rds++;
      end
      if (seq_done) dones++;
      if (pc_load && pc_n == 0) pc_n = n;
      if (core_run && run_n == 0) run_n = n;
      if (n == STAB + 4) chk("R6 word0 not yet", 64'(opt_regs[DW-1:0]), 64'd0);
      if (n == STAB + 5) chk("R6 word0 landed", 64'(opt_regs[DW-1:0]), 64'(pat(0, s)));
    end
    chk("R2 R3 first read edge", 64'(first_rd), 64'(STAB + 3));
    chk("R4 pc_load edge", 64'(pc_n), 64'(STAB + LOAD + 3));
    chk("R8 run edge", 64'(run_n), 64'(STAB + LOAD + 4));
    chk("R7 R9 done pulses", 64'(dones), 64'd1);
    chk("R5 read count", 64'(rds), 64'(NW));
    chk("R5 address order", 64'(addr_bad), 64'd0);
    for (int k = 0; k < NW; k++)
      chk("R6 option word", 64'(opt_regs[k*DW +: DW]), 64'(pat(k, s)));
    snap = opt_regs;
    seed = ~s;
    opt_rdata = ~opt_rdata;
    repeat (6) @(negedge clk);
    chk("R10 regs unchanged", 64'(opt_regs), 64'(snap));
    chk("R8 still running", {63'd0, core_run}, 64'd1);
    chk("R7 pc_load low", {63'd0, pc_load}, 64'd0);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(1);
    check_cleared("R1 time zero");
    run_seq(8'h00);
    run_seq(8'hA5);
    run_seq(8'h3C);

    // R1: asynchronous clear while running
    @(negedge clk); #(CLK_P/4);
    rst_n = 1'b0; #1;
    check_cleared("R1 async in run");

    // R11: reset in the middle of the load window
    seed = 8'h5A;
    @(negedge clk); rst_n = 1'b1;
    repeat (STAB + 3 + 5) @(negedge clk);
    chk("R11 word0 loaded before abort", 64'(opt_regs[DW-1:0]), 64'(pat(0, 8'h5A)));
    #(CLK_P/4); rst_n = 1'b0; #1;
    check_cleared("R11 abort clears");
    run_seq(8'hC3);

    // R4: full default configuration
    begin
      int n = 0, pc_n = 0;
      seed = 8'h96;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      while (pc_n == 0 && n < F_STAB + F_LOAD + 20) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (f_pc) pc_n = n;
      end
      chk("R4 full pc_load edge", 64'(pc_n), 64'(F_STAB + F_LOAD + 3));
      chk("R9 full done", {63'd0, f_done}, 64'd1);
      for (int k = 0; k < F_NW; k++)
        chk("R6 full option word", 64'(f_regs[k*DW +: DW]), 64'(pat(k, 8'h96)));
      @(negedge clk);
      chk("R8 full run", {63'd0, f_run}, 64'd1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule